// File: doc/BRIEF.md
# Two-Level Mipmap Box Downsampler

This unit accepts a square tile of 8-bit greyscale pixels, one per cycle in raster order, and produces two reduced images at once. One is at half resolution: each output is the mean of a 2x2 input block. The other is at quarter resolution: each output is the mean of a 4x4 input block. Both reduced images leave on their own valid/ready ports. Each output port also carries a flag that marks the first pixel of every output row.

Each pair of horizontally neighbouring pixels is first added into a 9-bit pair sum. Even-row pair sums wait in a 16-entry line store until the matching odd-row pair arrives. The resulting 10-bit 2x2 sum is narrowed by a right shift of 2 to give the half-scale pixel. The same untruncated 2x2 sum also goes into one of eight 12-bit quarter accumulators. The first 2x2 sum of a 4x4 block loads its accumulator, and the later ones add to it. When the fourth sum arrives, the total is narrowed by a right shift of 4. The quarter image therefore never inherits the rounding loss of the half image.

The input is back-pressured whenever either output holds data that has not been taken. No result is ever dropped. A control state machine has two states:

- `ST_IDLE`: waiting for a tile. Pixels without the tile-start flag are consumed and discarded (transition `T_DROP`). A pixel with the flag moves the machine to `ST_RUN` (transition `T_START`).
- `ST_RUN`: inside a tile. The last pixel of the tile returns the machine to `ST_IDLE` (transition `T_END`). A pixel flagged as tile start while in `ST_RUN` clears the partial-sum storage and becomes pixel 0 of a new tile (transition `T_RESTART`). Any other pixel advances the position (transition `T_STEP`).

Top module: `mip_downsampler`

## Requirements
- R1: Every half-scale output equals the sum of its 2x2 input block shifted right by 2 (truncated). A 32x32 tile yields these outputs in raster order of the 16x16 result.
- R2: Every quarter-scale output equals the sum of its 4x4 input block shifted right by 4 (truncated), computed from full sums. A tile whose 2x2 sums are 3, 3, 3 and 7 gives a quarter value of 1, not the 0 that averaging truncated half values would give.
- R3: A tile with every pixel at 255 gives 255 on every output of both levels (no overflow).
- R4: A full tile produces exactly 256 half-scale and 64 quarter-scale outputs. The row-start flag is 1 on output column 0 of each row and 0 elsewhere.
- R5: While an output's valid is 1 and its ready is 0, that output's data and row-start flag stay unchanged and valid stays 1.
- R6: While either output has valid 1 and ready 0, in_ready is 0. No output value is lost or duplicated under any ready pattern.
- R7: In `ST_IDLE`, pixels with in_sof at 0 produce no output. Only a pixel with in_sof at 1 starts a tile.
- R8: A pixel with in_sof at 1 in the middle of a tile aborts that tile. Outputs whose blocks were complete before the abort are still delivered. The new tile is then processed from scratch.
- R9: After reset both output valids are 0 and in_ready is 1.
- R10: Each quarter-scale output is issued in the same cycle as the half-scale output that completes its 4x4 block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel is present |
| in_ready | output | 1 | Unit can take a pixel this cycle |
| in_data | input | 8 | Input pixel value |
| in_sof | input | 1 | Marks pixel 0 of a tile |
| half_valid | output | 1 | Half-scale pixel present |
| half_ready | input | 1 | Consumer takes the half-scale pixel |
| half_data | output | 8 | Half-scale pixel value |
| half_row_start | output | 1 | Half-scale pixel is column 0 of its row |
| quar_valid | output | 1 | Quarter-scale pixel present |
| quar_ready | input | 1 | Consumer takes the quarter-scale pixel |
| quar_data | output | 8 | Quarter-scale pixel value |
| quar_row_start | output | 1 | Quarter-scale pixel is column 0 of its row |

## Verification
Two functions meet in one cycle: the last pixel of every 4x4 block issues a half-scale result and a quarter-scale result together, and both output slots load on the same edge. The bench provokes this overlap under skewed ready patterns on the two ports. Half is stalled every third cycle, and quarter is stalled for four cycles out of seven. This means sometimes one port, sometimes the other and sometimes both are full when the joint issue comes. The bench judges the overlap by three measures. Both collected streams must match the reference means in content and order. A stalled port must keep its value until taken. in_ready must stay low whenever either port is stalled.

// File: rtl/mip_pkg.sv
package mip_pkg;

    // Tile control states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mip_state_e;

endpackage

// File: rtl/mip_pair_adder.sv
// Horizontal pair adder: holds the even-column pixel and adds the odd one
// at full width.
module mip_pair_adder #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             odd,
    input  logic [PIX_W-1:0] pix,
    output logic [PIX_W:0]   pair_sum
);
    logic [PIX_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (en && !odd) begin
            hold_q <= pix;
        end
    end

    assign pair_sum = {1'b0, hold_q} + {1'b0, pix};
endmodule

// File: rtl/mip_line_store.sv
// Line store of even-row pair sums, one entry per half-scale column.
module mip_line_store #(
    parameter int DEPTH = 16,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);
    logic [W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (clr) begin
                mem[e] <= '0;
            end else if (wr && (idx == AW'(e))) begin
                mem[e] <= din;
            end
        end
    end

    assign dout = mem[idx];
endmodule

// File: rtl/mip_quad_acc.sv
// Bank of quarter-level accumulators. sum_out is the total of the
// selected entry plus the addend.
module mip_quad_acc #(
    parameter int DEPTH = 8,
    parameter int IN_W  = 10,
    parameter int ACC_W = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             load,
    input  logic [AW-1:0]    idx,
    input  logic [IN_W-1:0]  addend,
    output logic [ACC_W-1:0] sum_out
);
    logic [ACC_W-1:0] acc [DEPTH];

    assign sum_out = acc[idx] + ACC_W'(addend);

    for (genvar e = 0; e < DEPTH; e++) begin : g_acc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc[e] <= '0;
            end else if (clr) begin
                acc[e] <= '0;
            end else if (en && (idx == AW'(e))) begin
                acc[e] <= load ? ACC_W'(addend) : sum_out;
            end
        end
    end
endmodule

// File: rtl/mip_out_slot.sv
// Single-entry output slot with valid/ready handshake.
module mip_out_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    input  logic         ld_first,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] data,
    output logic         first,
    output logic         free
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            first <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= ld_data;
            first <= ld_first;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    assign free = !valid || ready;
endmodule

// File: rtl/mip_downsampler.sv
module mip_downsampler
    import mip_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int TILE  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_sof,
    output logic             half_valid,
    input  logic             half_ready,
    output logic [PIX_W-1:0] half_data,
    output logic             half_row_start,
    output logic             quar_valid,
    input  logic             quar_ready,
    output logic [PIX_W-1:0] quar_data,
    output logic             quar_row_start
);
    localparam int CW     = $clog2(TILE);
    localparam int HALF_N = TILE / 2;
    localparam int QUAR_N = TILE / 4;
    localparam int PAIR_W = PIX_W + 1;
    localparam int HSUM_W = PIX_W + 2;
    localparam int QSUM_W = PIX_W + 4;

    mip_state_e state_q, state_d;
    logic [CW-1:0] col_q, row_q, col_d, row_d;
    logic [CW-1:0] cur_col, cur_row;
    logic accept, live, restart, last_px;
    logic half_free, quar_free;
    logic line_wr, half_emit, quar_emit, acc_en, acc_load;
    logic [PAIR_W-1:0] pair_sum, line_dout;
    logic [HSUM_W-1:0] vsum;
    logic [QSUM_W-1:0] quad_total;
    logic [CW-2:0] pair_idx;
    logic [CW-3:0] quad_idx;

    assign in_ready = half_free && quar_free;
    assign accept   = in_valid && in_ready;
    assign cur_col  = in_sof ? '0 : col_q;
    assign cur_row  = in_sof ? '0 : row_q;
    assign pair_idx = cur_col[CW-1:1];
    assign quad_idx = cur_col[CW-1:2];
    assign last_px  = (cur_col == CW'(TILE-1)) && (cur_row == CW'(TILE-1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            row_q   <= row_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d = state_q;
        col_d   = col_q;
        row_d   = row_q;
        live    = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && in_sof) begin          // T_START
                    live    = 1'b1;
                    state_d = ST_RUN;
                    col_d   = CW'(1);
                    row_d   = '0;
                end                                   // else T_DROP
            end
            ST_RUN: begin
                if (accept) begin
                    live = 1'b1;
                    if (in_sof) begin                 // T_RESTART
                        restart = 1'b1;
                        col_d   = CW'(1);
                        row_d   = '0;
                    end else if (last_px) begin       // T_END
                        state_d = ST_IDLE;
                        col_d   = '0;
                        row_d   = '0;
                    end else begin                    // T_STEP
                        col_d = col_q + CW'(1);
                        if (col_q == CW'(TILE-1)) begin
                            row_d = row_q + CW'(1);
                        end
                    end
                end
            end
        endcase
    end

    // Datapath enables
    assign line_wr   = live && cur_col[0] && !cur_row[0];
    assign half_emit = live && cur_col[0] && cur_row[0];
    assign quar_emit = half_emit && cur_row[1] && cur_col[1];
    assign acc_en    = half_emit && !quar_emit;
    assign acc_load  = !cur_row[1] && !cur_col[1];
    assign vsum      = HSUM_W'(line_dout) + HSUM_W'(pair_sum);

    mip_pair_adder #(.PIX_W(PIX_W)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (live),
        .odd      (cur_col[0]),
        .pix      (in_data),
        .pair_sum (pair_sum)
    );

    mip_line_store #(.DEPTH(HALF_N), .W(PAIR_W)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .wr    (line_wr),
        .idx   (pair_idx),
        .din   (pair_sum),
        .dout  (line_dout)
    );

    mip_quad_acc #(.DEPTH(QUAR_N), .IN_W(HSUM_W), .ACC_W(QSUM_W)) u_quad (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .en      (acc_en),
        .load    (acc_load),
        .idx     (quad_idx),
        .addend  (vsum),
        .sum_out (quad_total)
    );

    mip_out_slot #(.W(PIX_W)) u_half_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (half_emit),
        .ld_data  (vsum[HSUM_W-1:2]),
        .ld_first (pair_idx == '0),
        .ready    (half_ready),
        .valid    (half_valid),
        .data     (half_data),
        .first    (half_row_start),
        .free     (half_free)
    );

    mip_out_slot #(.W(PIX_W)) u_quar_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (quar_emit),
        .ld_data  (quad_total[QSUM_W-1:4]),
        .ld_first (quad_idx == '0),
        .ready    (quar_ready),
        .valid    (quar_valid),
        .data     (quar_data),
        .first    (quar_row_start),
        .free     (quar_free)
    );
endmodule

// File: rtl/mip_checker.sv
module mip_checker #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             half_valid,
    input logic             half_ready,
    input logic [PIX_W-1:0] half_data,
    input logic             half_row_start,
    input logic             quar_valid,
    input logic             quar_ready,
    input logic [PIX_W-1:0] quar_data,
    input logic             quar_row_start
);
    assert_half_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (half_valid && !half_ready) |=>
            (half_valid && $stable(half_data) && $stable(half_row_start)));

    assert_quar_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (quar_valid && !quar_ready) |=>
            (quar_valid && $stable(quar_data) && $stable(quar_row_start)));

    assert_half_stall_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (half_valid && !half_ready) |-> !in_ready);

    assert_quar_stall_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (quar_valid && !quar_ready) |-> !in_ready);

    assert_joint_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(quar_valid) || (quar_valid && !$stable(quar_data))) |-> half_valid);
endmodule

bind mip_downsampler mip_checker #(.PIX_W(PIX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_ready       (in_ready),
    .half_valid     (half_valid),
    .half_ready     (half_ready),
    .half_data      (half_data),
    .half_row_start (half_row_start),
    .quar_valid     (quar_valid),
    .quar_ready     (quar_ready),
    .quar_data      (quar_data),
    .quar_row_start (quar_row_start)
);

// File: tb/sim_mip_downsampler.sv
`timescale 1ns/1ps
module sim_mip_downsampler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       half_valid, half_ready, half_row_start;
    logic [7:0] half_data;
    logic       quar_valid, quar_ready, quar_row_start;
    logic [7:0] quar_data;

    always #2 clk = ~clk;   // 250 MHz

    mip_downsampler u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
        .half_valid(half_valid), .half_ready(half_ready),
        .half_data(half_data), .half_row_start(half_row_start),
        .quar_valid(quar_valid), .quar_ready(quar_ready),
        .quar_data(quar_data), .quar_row_start(quar_row_start)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int hmode   = 0;
    int qmode   = 0;
    int img [32][32];
    logic [8:0] exp_h[$], exp_q[$], got_h[$], got_q[$];
    int hold_err = 0, bp_err = 0, joint_cnt = 0;
    logic       prev_hs = 0, prev_qs = 0;
    logic [8:0] prev_hv = '0, prev_qv = '0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // ready patterns driven just after the rising edge
    function automatic logic pick(input int mode, input int c);
        if (mode == 1) return (c % 3) != 0;
        if (mode == 2) return (c % 7) >= 4;
        return 1'b1;
    endfunction

    initial begin
        half_ready = 1'b1;
        quar_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            half_ready = pick(hmode, cyc);
            quar_ready = pick(qmode, cyc);
            if (cyc > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    // monitor sampled at the falling edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (half_valid && half_ready) got_h.push_back({half_row_start, half_data});
            if (quar_valid && quar_ready) got_q.push_back({quar_row_start, quar_data});
            if (prev_hs && (!half_valid || {half_row_start, half_data} != prev_hv)) hold_err++;
            if (prev_qs && (!quar_valid || {quar_row_start, quar_data} != prev_qv)) hold_err++;
            if (((half_valid && !half_ready) || (quar_valid && !quar_ready)) && in_ready) bp_err++;
            if (half_valid && quar_valid && (!half_ready || !quar_ready)) joint_cnt++;
            prev_hs = half_valid && !half_ready;
            prev_qs = quar_valid && !quar_ready;
            prev_hv = {half_row_start, half_data};
            prev_qv = {quar_row_start, quar_data};
        end
    end

    task automatic clear_obs();
        exp_h.delete(); exp_q.delete(); got_h.delete(); got_q.delete();
        hold_err = 0; bp_err = 0; joint_cnt = 0;
    endtask

    // kind 0 ramp, 1 all 255, 2 truncation pattern, 3 pseudo-random
    task automatic fill(input int kind, input int seed);
        int s = seed;
        for (int y = 0; y < 32; y++) begin
            for (int x = 0; x < 32; x++) begin
                case (kind)
                    0: img[y][x] = (x * 7 + y * 13 + seed) & 255;
                    1: img[y][x] = 255;
                    2: img[y][x] = ((x % 2 == 1) && (y % 2 == 1)) ?
                                   (((x % 4 == 3) && (y % 4 == 3)) ? 4 : 0) : 1;
                    default: begin
                        s = (s * 1103515245 + 12345) & 32'h7fffffff;
                        img[y][x] = (s >> 16) & 255;
                    end
                endcase
            end
        end
    endtask

    // reference outputs for the first n pixels of the current image
    task automatic expect_tile(input int n);
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                if ((2*r+1)*32 + 2*c + 1 < n) begin
                    int s = img[2*r][2*c] + img[2*r][2*c+1] + img[2*r+1][2*c] + img[2*r+1][2*c+1];
                    exp_h.push_back({(c == 0), 8'(s >> 2)});
                end
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                if ((4*r+3)*32 + 4*c + 3 < n) begin
                    int s = 0;
                    for (int dy = 0; dy < 4; dy++)
                        for (int dx = 0; dx < 4; dx++)
                            s += img[4*r+dy][4*c+dx];
                    exp_q.push_back({(c == 0), 8'(s >> 4)});
                end
    endtask

    task automatic send_px(input int v, input bit sof, input bit gap);
        if (gap) begin
            in_valid = 1'b0;
            @(posedge clk); #1;
        end
        in_valid = 1'b1;
        in_data  = 8'(v);
        in_sof   = sof;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic send_tile(input int n, input bit gaps);
        for (int i = 0; i < n; i++)
            send_px(img[i / 32][i % 32], (i == 0), gaps && ((i % 11) == 5));
    endtask

    task automatic drain();
        repeat (200) @(posedge clk);
        #1;
    endtask

    task automatic compare(input string tag);
        int bad_h = -1, bad_q = -1;
        check(got_h.size() == exp_h.size(), {tag, " R4 half count"}, got_h.size(), exp_h.size());
        check(got_q.size() == exp_q.size(), {tag, " R4 quarter count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_h.size() && i < got_h.size(); i++)
            if (bad_h < 0 && got_h[i] != exp_h[i]) bad_h = i;
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (bad_q < 0 && got_q[i] != exp_q[i]) bad_q = i;
        check(bad_h < 0, {tag, " R1 half values and row_start"},
              (bad_h < 0) ? 0 : int'(got_h[bad_h]), (bad_h < 0) ? 0 : int'(exp_h[bad_h]));
        check(bad_q < 0, {tag, " R2 quarter values and row_start"},
              (bad_q < 0) ? 0 : int'(got_q[bad_q]), (bad_q < 0) ? 0 : int'(exp_q[bad_q]));
    endtask

    task automatic t_reset();
        check(half_valid == 1'b0, "R9 half_valid after reset", half_valid, 0);
        check(quar_valid == 1'b0, "R9 quar_valid after reset", quar_valid, 0);
        check(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);
    endtask

    task automatic t_ramp();
        clear_obs(); fill(0, 3); expect_tile(1024);
        send_tile(1024, 1'b0); drain();
        compare("ramp");
    endtask

    task automatic t_full();
        clear_obs(); fill(1, 0); expect_tile(1024);
        send_tile(1024, 1'b0); drain();
        compare("all255 R3");
        check(got_h.size() > 0 && got_h[0][7:0] == 8'd255, "R3 half saturates to 255",
              (got_h.size() > 0) ? int'(got_h[0][7:0]) : -1, 255);
        check(got_q.size() > 0 && got_q[got_q.size()-1][7:0] == 8'd255, "R3 quarter reaches 255",
              (got_q.size() > 0) ? int'(got_q[got_q.size()-1][7:0]) : -1, 255);
    endtask

    task automatic t_trunc();
        int alt;
        clear_obs(); fill(2, 0); expect_tile(1024);
        send_tile(1024, 1'b0); drain();
        compare("trunc");
        alt = ((img[0][0]+img[0][1]+img[1][0]+img[1][1]) / 4 + (img[0][2]+img[0][3]+img[1][2]+img[1][3]) / 4
             + (img[2][0]+img[2][1]+img[3][0]+img[3][1]) / 4 + (img[2][2]+img[2][3]+img[3][2]+img[3][3]) / 4) / 4;
        check(got_q.size() > 0 && got_q[0][7:0] == 8'd1 && alt == 0,
              "R2 quarter from full sums, not truncated halves",
              (got_q.size() > 0) ? int'(got_q[0][7:0]) : -1, 1);
    endtask

    task automatic t_backpressure();
        clear_obs(); fill(3, 77); expect_tile(1024);
        hmode = 1; qmode = 2;
        send_tile(1024, 1'b1);
        drain();
        hmode = 0; qmode = 0;
        drain();
        compare("stall R6");
        check(hold_err == 0, "R5 stalled output held stable", hold_err, 0);
        check(bp_err == 0, "R6 in_ready low during stall", bp_err, 0);
        check(joint_cnt > 0, "R10 joint issue met a stall", joint_cnt, 1);
    endtask

    task automatic t_pre_sof();
        clear_obs();
        for (int i = 0; i < 6; i++) send_px(i * 40, 1'b0, 1'b0);
        repeat (5) @(posedge clk); #1;
        check(got_h.size() == 0 && !half_valid && !quar_valid, "R7 pixels without sof ignored",
              got_h.size() + half_valid + quar_valid, 0);
        fill(0, 91); expect_tile(1024);
        send_tile(1024, 1'b0); drain();
        compare("presof R7");
    endtask

    task automatic t_abort();
        clear_obs();
        fill(3, 5); expect_tile(234);
        send_tile(234, 1'b0);
        fill(0, 200); expect_tile(1024);
        send_tile(1024, 1'b0); drain();
        compare("abort R8");
        check(got_h.size() == 53 + 256, "R8 halves of aborted tile kept", got_h.size(), 309);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        @(posedge clk); #1;
        t_ramp();
        t_full();
        t_trunc();
        t_backpressure();
        t_pre_sof();
        t_abort();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule